// File: doc/BRIEF.md
# Simulation Control Port Peripheral

This peripheral sits on the I/O write bus of an 8-bit processor inside a simulation environment. It gives the program under test a way to report a verdict, send text lines to the host, guard itself with a watchdog and schedule an interrupt. It decodes writes to a 32-port control window at 0x80 to 0x9F and ignores every other I/O address. The range 0x10 to 0x1F belongs to other test devices.

The verdict port latches pass and fail flags and controls a waveform-dump request level. The message port gathers characters into a line buffer, and a newline publishes that line together with a one-cycle strobe. A watchdog counts clocks against a programmable 16-bit limit and raises a sticky error flag when it reaches the limit. A countdown port pulls an active-low interrupt line after a programmed number of clocks. The harness acts on the outputs: it ends the run, prints the line or toggles dumping.

Top module: `simctl_periph`

## Requirements
- R1: Only writes (`io_wr`=1) whose address lies in 0x80..0x9F have any effect. Writes to any other address, including 0x00..0x7F and 0xA0..0xFF, leave every output unchanged, and so do writes to window offsets that are not assigned.
- R2: Writing 0x01 to port 0x80 sets `run_passed` on the next clock. It then stays set until reset, whatever is written afterwards.
- R3: Writing 0x02 to port 0x80 sets `run_failed` on the next clock. It then stays set until reset.
- R4: At port 0x80, the value 0x03 sets `dump_on` and the value 0x04 clears it. Any other value leaves `dump_on` unchanged.
- R5: Each write to port 0x81 of a byte other than 0x0A appends that byte to the line buffer. Writing 0x0A stores nothing. On the next clock it raises `line_valid` for one cycle, sets `line_len` to the number of stored characters and empties the buffer. While `line_valid` is high, character i of the line is on `line_data[8*i+7:8*i]`.
- R6: The buffer holds at most 64 characters. Characters that arrive while it is full are dropped until the next newline, so `line_len` never exceeds 64.
- R7: Port 0x82 controls the watchdog: bit 0 enables counting and bit 1 clears the count to zero. After reset the watchdog is enabled with a count of zero. While it is disabled it does not advance.
- R8: Port 0x83 sets the low byte and port 0x84 sets the high byte of the watchdog limit, which resets to 0xFFFF. When a clear-and-enable write is followed by no further watchdog writes, `timeout_err` rises after the (limit+1)-th following clock and then stays set until reset.
- R9: Writing a nonzero value N to port 0x90 releases `irq_n` high and starts a countdown. `irq_n` goes low on the N-th clock after the write and stays low. A new nonzero write restarts the countdown from its own value.
- R10: Writing 0x00 to port 0x90 drives `irq_n` high on the next clock and cancels any countdown in progress.
- R11: While reset is held, `run_passed`, `run_failed`, `dump_on`, `line_valid` and `timeout_err` are 0, `line_len` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| run_passed | output | 1 | Sticky pass verdict |
| run_failed | output | 1 | Sticky fail verdict |
| dump_on | output | 1 | Waveform-dump request level |
| line_valid | output | 1 | One-cycle strobe: a finished line is presented |
| line_len | output | 7 | Number of characters in the presented line |
| line_data | output | 512 | Line characters, character i in bits 8i+7..8i |
| timeout_err | output | 1 | Sticky watchdog timeout flag |
| irq_n | output | 1 | Active-low interrupt from the countdown |

## Verification
The watchdog is the hardest part to reach. It runs from reset with a limit of 0xFFFF, and its error flag is sticky, so one early expiry would hide every later timing check. The stimulus therefore first disables and clears the counter and then lowers the limit one byte at a time while counting is held off. It confirms that a disabled watchdog stays silent, then re-arms the counter, clears it again partway through and times the expiry from that second clear. The line buffer is filled well past its capacity before a newline is sent, which tests the dropped characters and the length cap in the same run.

// File: rtl/simctl_pkg.sv
// simctl_pkg: port offsets and command codes shared by the simulation
// control peripheral. Assumes an 8-bit I/O address with a 32-port window.
package simctl_pkg;
    localparam logic [7:0] WIN_FIRST   = 8'h80;
    localparam logic [7:0] WIN_LAST    = 8'h9F;
    localparam int         OFF_W       = 5;

    localparam logic [OFF_W-1:0] OFF_VERDICT = 5'h00;
    localparam logic [OFF_W-1:0] OFF_MSG     = 5'h01;
    localparam logic [OFF_W-1:0] OFF_WDCTL   = 5'h02;
    localparam logic [OFF_W-1:0] OFF_LIM_LO  = 5'h03;
    localparam logic [OFF_W-1:0] OFF_LIM_HI  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_IRQ     = 5'h10;

    typedef enum logic [7:0] {
        CMD_PASS     = 8'h01,
        CMD_FAIL     = 8'h02,
        CMD_DUMP_ON  = 8'h03,
        CMD_DUMP_OFF = 8'h04
    } verdict_cmd_e;

    localparam logic [7:0] CHAR_NEWLINE = 8'h0A;
endpackage

// File: rtl/simctl_verdict.sv
// simctl_verdict: latches the pass/fail verdict and the dump request.
// Assumes cmd_wr is a one-cycle strobe already qualified by address decode.
module simctl_verdict
    import simctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_val,
    output logic       passed,
    output logic       failed,
    output logic       dump
);
    // Verdict flags: set by their code, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            passed <= 1'b0;
            failed <= 1'b0;
        end else if (cmd_wr) begin
            if (cmd_val == CMD_PASS) passed <= 1'b1;
            if (cmd_val == CMD_FAIL) failed <= 1'b1;
        end
    end

    // Dump level: set and cleared by its two codes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dump <= 1'b0;
        end else if (cmd_wr) begin
            if (cmd_val == CMD_DUMP_ON)       dump <= 1'b1;
            else if (cmd_val == CMD_DUMP_OFF) dump <= 1'b0;
        end
    end

    assert_pass_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        passed |=> passed);
    assert_fail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        failed |=> failed);
    assert_dump_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(dump));
endmodule

// File: rtl/simctl_msgbuf.sv
// simctl_msgbuf: collects characters into a line buffer and publishes the
// line on newline. Stored bytes are not reset; only bytes below line_len
// are meaningful while line_valid is high.
module simctl_msgbuf
    import simctl_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               char_wr,
    input  logic [7:0]         char_in,
    output logic               line_valid,
    output logic [LEN_W-1:0]   line_len,
    output logic [8*DEPTH-1:0] line_data
);
    logic [7:0]       store_q [DEPTH];
    logic [LEN_W-1:0] fill_q;
    logic             is_nl;
    logic             has_room;

    // Classify the incoming byte and check for free space.
    always_comb begin
        is_nl    = (char_in == CHAR_NEWLINE);
        has_room = (fill_q < LEN_W'(DEPTH));
    end

    // Fill level, publish strobe and published length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q     <= '0;
            line_valid <= 1'b0;
            line_len   <= '0;
        end else begin
            line_valid <= 1'b0;
            if (char_wr) begin
                if (is_nl) begin
                    line_valid <= 1'b1;
                    line_len   <= fill_q;
                    fill_q     <= '0;
                end else if (has_room) begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

    // Character storage: write at the current fill position.
    always_ff @(posedge clk) begin
        if (char_wr && !is_nl && has_room)
            store_q[fill_q[IDX_W-1:0]] <= char_in;
    end

    // Present the storage as a flat line, character i in byte lane i.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        assign line_data[8*g +: 8] = store_q[g];
    end

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= LEN_W'(DEPTH));
    assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && is_nl) |=> (line_valid && fill_q == '0));
    assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_wr && is_nl) |=> !line_valid);
endmodule

// File: rtl/simctl_watchdog.sv
// simctl_watchdog: clock counter against a byte-written limit, with a
// sticky error. Assumes the write strobes are one cycle and decoded.
module simctl_watchdog #(
    parameter int          TMO_W     = 16,
    parameter logic [15:0] LIM_RESET = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       lim_lo_wr,
    input  logic       lim_hi_wr,
    input  logic [7:0] wdata,
    output logic       err
);
    logic [TMO_W-1:0] count_q;
    logic [TMO_W-1:0] limit_q;
    logic             en_q;
    logic             clr_req;
    logic             at_limit;
    logic [5:0]       unused_ctl_bits;

    // Decode the control byte and compare against the limit.
    always_comb begin
        clr_req         = ctl_wr && wdata[1];
        at_limit        = (count_q >= limit_q);
        unused_ctl_bits = wdata[7:2];
    end

    // Enable bit: on out of reset, rewritten by the control port.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b1;
        else if (ctl_wr) en_q <= wdata[0];
    end

    // Limit register: two byte lanes written separately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= TMO_W'(LIM_RESET);
        end else begin
            if (lim_lo_wr) limit_q[7:0]       <= wdata;
            if (lim_hi_wr) limit_q[TMO_W-1:8] <= wdata[TMO_W-9:0];
        end
    end

    // Counter: clears on request, advances while enabled and below limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count_q <= '0;
        else if (clr_req)               count_q <= '0;
        else if (en_q && !at_limit)     count_q <= count_q + 1'b1;
    end

    // Error flag: set once the enabled count reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 err <= 1'b0;
        else if (en_q && at_limit && !clr_req)      err <= 1'b1;
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (count_q == '0));
    assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctl_wr) |=> $stable(count_q));
endmodule

// File: rtl/simctl_irqtimer.sv
// simctl_irqtimer: clock countdown that drives an active-low interrupt.
// A zero load releases the line and cancels; a nonzero load restarts.
module simctl_irqtimer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic             irq_n
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             fire_q;

    // Countdown state and interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            fire_q  <= 1'b0;
        end else if (load_wr) begin
            cnt_q   <= load_val;
            armed_q <= (load_val != '0);
            fire_q  <= 1'b0;
        end else if (armed_q) begin
            if (cnt_q == CNT_W'(1)) begin
                armed_q <= 1'b0;
                fire_q  <= 1'b1;
            end
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Active-low output.
    always_comb irq_n = !fire_q;

    assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && load_val == '0) |=> (irq_n && !armed_q));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && load_val != '0) |=> (irq_n && armed_q && cnt_q == $past(load_val)));
    assert_low_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !load_wr) |=> !irq_n);
endmodule

// File: rtl/simctl_periph.sv
// simctl_periph: decodes I/O writes in the control window and routes them
// to the verdict, message, watchdog and interrupt-countdown units.
// Assumes io_wr is high for exactly one cycle per bus write.
module simctl_periph
    import simctl_pkg::*;
#(
    parameter int          MSG_DEPTH = 64,
    parameter int          TMO_W     = 16,
    parameter logic [15:0] TMO_RESET = 16'hFFFF,
    parameter int          IRQ_W     = 8,
    localparam int         LEN_W     = $clog2(MSG_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             io_addr,
    input  logic [7:0]             io_wdata,
    input  logic                   io_wr,
    output logic                   run_passed,
    output logic                   run_failed,
    output logic                   dump_on,
    output logic                   line_valid,
    output logic [LEN_W-1:0]       line_len,
    output logic [8*MSG_DEPTH-1:0] line_data,
    output logic                   timeout_err,
    output logic                   irq_n
);
    logic             win_hit;
    logic [OFF_W-1:0] off;
    logic             wr_verdict, wr_msg, wr_wdctl, wr_lim_lo, wr_lim_hi, wr_irq;

    // Window decode and per-port write strobes.
    always_comb begin
        win_hit    = io_wr && (io_addr >= WIN_FIRST) && (io_addr <= WIN_LAST);
        off        = io_addr[OFF_W-1:0];
        wr_verdict = win_hit && (off == OFF_VERDICT);
        wr_msg     = win_hit && (off == OFF_MSG);
        wr_wdctl   = win_hit && (off == OFF_WDCTL);
        wr_lim_lo  = win_hit && (off == OFF_LIM_LO);
        wr_lim_hi  = win_hit && (off == OFF_LIM_HI);
        wr_irq     = win_hit && (off == OFF_IRQ);
    end

    simctl_verdict u_verdict (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (wr_verdict),
        .cmd_val (io_wdata),
        .passed  (run_passed),
        .failed  (run_failed),
        .dump    (dump_on)
    );

    simctl_msgbuf #(.DEPTH(MSG_DEPTH)) u_msgbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_wr    (wr_msg),
        .char_in    (io_wdata),
        .line_valid (line_valid),
        .line_len   (line_len),
        .line_data  (line_data)
    );

    simctl_watchdog #(.TMO_W(TMO_W), .LIM_RESET(TMO_RESET)) u_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (wr_wdctl),
        .lim_lo_wr (wr_lim_lo),
        .lim_hi_wr (wr_lim_hi),
        .wdata     (io_wdata),
        .err       (timeout_err)
    );

    simctl_irqtimer #(.CNT_W(IRQ_W)) u_irqtimer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_wr  (wr_irq),
        .load_val (io_wdata[IRQ_W-1:0]),
        .irq_n    (irq_n)
    );

    assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !win_hit) |=> ($stable(run_passed) && $stable(run_failed)
                                 && $stable(dump_on) && !line_valid));
endmodule

// File: tb/tb_simctl_periph.sv
module tb_simctl_periph;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   io_addr = '0;
    logic [7:0]   io_wdata = '0;
    logic         io_wr = 1'b0;
    logic         run_passed, run_failed, dump_on, line_valid, timeout_err, irq_n;
    logic [6:0]   line_len;
    logic [511:0] line_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    simctl_periph dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .run_passed(run_passed), .run_failed(run_failed),
        .dump_on(dump_on), .line_valid(line_valid), .line_len(line_len),
        .line_data(line_data), .timeout_err(timeout_err), .irq_n(irq_n)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus write; returns at the falling edge after the write edge.
    task automatic io_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 passed", run_passed, 0);
        check("R11 failed", run_failed, 0);
        check("R11 dump", dump_on, 0);
        check("R11 line_valid", line_valid, 0);
        check("R11 line_len", line_len, 0);
        check("R11 timeout", timeout_err, 0);
        check("R11 irq_n", irq_n, 1);
    endtask

    task automatic t_watchdog();
        io_write(8'h82, 8'h02);           // R7: clear and disable
        io_write(8'h83, 8'd20);           // R8: low byte
        io_write(8'h84, 8'h00);           // R8: high byte
        wait_clk(60);
        check("R7 disabled no timeout", timeout_err, 0);
        io_write(8'h82, 8'h03);           // enable and clear
        wait_clk(10);
        io_write(8'h82, 8'h03);           // R7: clear mid-run
        wait_clk(20);
        check("R8 before limit", timeout_err, 0);
        wait_clk(1);
        check("R8 at limit", timeout_err, 1);
        io_write(8'h82, 8'h02);
        wait_clk(5);
        check("R8 sticky", timeout_err, 1);
    endtask

    task automatic t_ignored();
        io_write(8'h00, 8'h01);
        io_write(8'h11, 8'h01);
        io_write(8'hA0, 8'h03);
        io_write(8'h7F, 8'h01);
        io_write(8'h88, 8'h01);           // unassigned offset in window
        io_write(8'h01, 8'h0A);           // newline outside window
        check("R1 passed untouched", run_passed, 0);
        check("R1 dump untouched", dump_on, 0);
        check("R1 no line", line_valid, 0);
        io_write(8'h11, 8'd2);            // would be an irq load if decoded
        wait_clk(4);
        check("R1 irq untouched", irq_n, 1);
    endtask

    task automatic t_verdict();
        io_write(8'h80, 8'h05);
        check("R4 other code", dump_on, 0);
        io_write(8'h80, 8'h03);
        check("R4 dump on", dump_on, 1);
        io_write(8'h80, 8'h07);
        check("R4 hold", dump_on, 1);
        io_write(8'h80, 8'h04);
        check("R4 dump off", dump_on, 0);
        check("R2 not yet", run_passed, 0);
        io_write(8'h80, 8'h01);
        check("R2 passed", run_passed, 1);
        check("R3 not yet", run_failed, 0);
        io_write(8'h80, 8'h02);
        check("R3 failed", run_failed, 1);
        io_write(8'h80, 8'h04);
        io_write(8'h80, 8'h00);
        check("R2 sticky", run_passed, 1);
        check("R3 sticky", run_failed, 1);
    endtask

    task automatic t_message();
        string s = "Hello";
        for (int i = 0; i < s.len(); i++) io_write(8'h81, s[i]);
        check("R5 no early strobe", line_valid, 0);
        io_write(8'h81, 8'h0A);
        check("R5 strobe", line_valid, 1);
        check("R5 length", line_len, 5);
        for (int i = 0; i < s.len(); i++)
            check("R5 char", line_data[8*i +: 8], s[i]);
        wait_clk(1);
        check("R5 strobe one cycle", line_valid, 0);
        io_write(8'h81, 8'h0A);
        check("R5 empty line", line_len, 0);
        io_write(8'h81, "Z");
        io_write(8'h81, 8'h0A);
        check("R5 emptied after flush", line_len, 1);
        check("R5 first char", line_data[7:0], "Z");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 70; i++) io_write(8'h81, 8'h41 + 8'(i % 26));
        io_write(8'h81, 8'h0A);
        check("R6 capped length", line_len, 64);
        check("R6 last kept", line_data[8*63 +: 8], 8'h41 + 8'(63 % 26));
        check("R6 first", line_data[7:0], 8'h41);
    endtask

    task automatic t_irq();
        io_write(8'h90, 8'd5);
        wait_clk(4);
        check("R9 before count", irq_n, 1);
        wait_clk(1);
        check("R9 fires", irq_n, 0);
        wait_clk(10);
        check("R9 stays low", irq_n, 0);
        io_write(8'h90, 8'd0);
        check("R10 release", irq_n, 1);
        io_write(8'h90, 8'd10);
        wait_clk(5);
        io_write(8'h90, 8'd3);            // R9 restart
        wait_clk(2);
        check("R9 restart early", irq_n, 1);
        wait_clk(1);
        check("R9 restart fires", irq_n, 0);
        io_write(8'h90, 8'd8);
        check("R9 reload releases", irq_n, 1);
        wait_clk(3);
        io_write(8'h90, 8'd0);
        wait_clk(20);
        check("R10 cancelled", irq_n, 1);
    endtask

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        t_watchdog();
        t_ignored();
        t_message();
        t_overflow();
        t_irq();
        t_verdict();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule